// File: doc/BRIEF.md
# Display Power-Up Initialization Sequencer

This block drives the one-time start-up script of a character display controller that uses an 8-bit parallel bus. After reset it holds off for the supply settling interval. It then issues four instruction writes on a command port, in a fixed order: function set, display on/off control, clear, and entry mode. After each write it holds off for the minimum execution time of that instruction. All intervals are counted in clock cycles derived from a clock frequency parameter. A second parameter divides down only the long settling interval, so that simulation runs stay short.

Seven configuration inputs select the contents of the instructions: line count, font height, display enable, cursor enable, blink, address direction and whole-display shift. They are captured once, on the first clock after reset. When the last hold-off has elapsed, `initDone` goes high and stays high until the next reset. A scheduler downstream uses this signal to take over the command port.

Top module: `panel_init_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `cmdValid` and `initDone` are 0.
- R2: The first command strobe appears exactly P clock edges after reset release, with P = floor(floor(CLK_HZ*30000/1000000)/PWR_DIV)+1.
- R3: The first command is function set, 8'b0011_NF00: bit 3 (N) is `cfgTwoLines` and bit 2 (F) is `cfgTallFont`.
- R4: The second command is display control, 8'b0000_1DCB: bit 2 is `cfgDisplayOn`, bit 1 is `cfgCursorOn` and bit 0 is `cfgBlink`.
- R5: The third command is clear, 8'h01. The fourth is entry mode, 8'b0000_01IS: bit 1 is `cfgIncrement` and bit 0 is `cfgShiftAll`.
- R6: The gap from one command strobe to the next is S = floor(CLK_HZ*39/1000000)+1 edges after function set and after display control, and C = floor(CLK_HZ*1530/1000000)+1 edges after clear.
- R7: `initDone` rises exactly S edges after the entry-mode strobe. It then stays high until reset, and no strobe occurs while it is high.
- R8: Every strobe lasts one cycle, with `cmdRs` = 0 and `cmdRw` = 0.
- R9: The configuration inputs are sampled on the first clock edge after reset release. Later changes to them do not alter any command of that sequence.
- R10: Exactly four command strobes are issued per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; starts a new sequence on release |
| cfgTwoLines | input | 1 | 1 selects two display lines |
| cfgTallFont | input | 1 | 1 selects the 5x11 font |
| cfgDisplayOn | input | 1 | 1 turns the display on |
| cfgCursorOn | input | 1 | 1 shows the cursor |
| cfgBlink | input | 1 | 1 makes the cursor position blink |
| cfgIncrement | input | 1 | 1 makes the address count up after each access |
| cfgShiftAll | input | 1 | 1 shifts the whole display on each write |
| cmdValid | output | 1 | One-cycle strobe marking a command on `cmdData` |
| cmdData | output | 8 | Instruction code |
| cmdRs | output | 1 | Register select for the write, always 0 |
| cmdRw | output | 1 | Read/write select, always 0 (write) |
| initDone | output | 1 | High once the script has finished; command-port ownership passes on |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the configuration inputs are settled by the first edge after release, since the sampling register takes whatever is present at that edge. The stimulus sets each of the 128 configuration patterns while reset is low. It then flips every configuration bit to its inverse two edges after release, so the captured values and the live inputs disagree for the rest of the sequence. The bench uses a small clock frequency parameter and a settling divider, which keeps a full sweep of patterns within its run time.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

  typedef enum logic [2:0] {
    STEP_PWR   = 3'd0,
    STEP_FUNC  = 3'd1,
    STEP_DISP  = 3'd2,
    STEP_CLR   = 3'd3,
    STEP_ENTRY = 3'd4
  } stepT;

  typedef struct packed {
    logic twoLines;
    logic tallFont;
    logic dispOn;
    logic cursorOn;
    logic blinkOn;
    logic increment;
    logic shiftAll;
  } panelCfgT;

  typedef struct packed {
    logic loadCfg;
    logic cntClear;
    logic cntRun;
    logic issue;
    logic done;
    stepT step;
  } seqStrobeT;

  function automatic logic [7:0] encodeCmd(input stepT s, input panelCfgT c);
    logic [7:0] code;
    case (s)
      STEP_FUNC:  code = {4'b0011, c.twoLines, c.tallFont, 2'b00};
      STEP_DISP:  code = {5'b00001, c.dispOn, c.cursorOn, c.blinkOn};
      STEP_CLR:   code = 8'h01;
      STEP_ENTRY: code = {6'b000001, c.increment, c.shiftAll};
      default:    code = 8'h00;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/panel_init_ctrl.sv
module panel_init_ctrl
  import panel_init_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cntHit,
  output seqStrobeT strb
);

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_WAIT  = 2'd1,
    PH_ISSUE = 2'd2,
    PH_DONE  = 2'd3
  } phaseT;

  phaseT phase;
  stepT  step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_START;
      step  <= STEP_PWR;
    end else begin
      case (phase)
        PH_START: begin
          phase <= PH_WAIT;
          step  <= STEP_PWR;
        end
        PH_WAIT: begin
          if (cntHit) begin
            case (step)
              STEP_PWR:   begin phase <= PH_ISSUE; step <= STEP_FUNC;  end
              STEP_FUNC:  begin phase <= PH_ISSUE; step <= STEP_DISP;  end
              STEP_DISP:  begin phase <= PH_ISSUE; step <= STEP_CLR;   end
              STEP_CLR:   begin phase <= PH_ISSUE; step <= STEP_ENTRY; end
              default:    phase <= PH_DONE;
            endcase
          end
        end
        PH_ISSUE: phase <= PH_WAIT;
        default:  phase <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    strb.loadCfg  = (phase == PH_START);
    strb.cntRun   = (phase == PH_WAIT);
    strb.cntClear = (phase != PH_WAIT) || cntHit;
    strb.issue    = (phase == PH_ISSUE);
    strb.done     = (phase == PH_DONE);
    strb.step     = step;
  end

  // An issued command is always followed by its own hold-off
  assert_issue_then_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ISSUE) |=> (phase == PH_WAIT) && $stable(step));

  // Once finished the sequencer never leaves the final phase
  assert_done_absorbing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |=> (phase == PH_DONE));

endmodule

// File: rtl/panel_init_dp.sv
module panel_init_dp
  import panel_init_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned PWR_DIV = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  seqStrobeT strb,
  input  panelCfgT  cfgIn,
  output logic      cntHit,
  output logic      cmdValid,
  output logic [7:0] cmdData,
  output logic      initDone
);

  localparam longint PWR_CYC   = ((longint'(CLK_HZ) * 30_000) / 1_000_000) / longint'(PWR_DIV) + 1;
  localparam longint SHORT_CYC = (longint'(CLK_HZ) * 39) / 1_000_000 + 1;
  localparam longint CLR_CYC   = (longint'(CLK_HZ) * 1_530) / 1_000_000 + 1;
  // Wait-phase lengths; the start phase and output register absorb two edges of power-up
  localparam longint LEN_PWR   = (PWR_CYC > 3) ? PWR_CYC - 2 : 1;
  localparam longint LEN_SHORT = (SHORT_CYC > 2) ? SHORT_CYC - 1 : 1;
  localparam longint LEN_CLR   = (CLR_CYC > 2) ? CLR_CYC - 1 : 1;
  localparam longint LEN_MAX   = (LEN_PWR > LEN_CLR) ? ((LEN_PWR > LEN_SHORT) ? LEN_PWR : LEN_SHORT)
                                                     : ((LEN_CLR > LEN_SHORT) ? LEN_CLR : LEN_SHORT);
  localparam int     CNT_W     = $clog2(LEN_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hitVal;
  panelCfgT         cfgQ;

  always_comb begin
    case (strb.step)
      STEP_PWR: hitVal = CNT_W'(LEN_PWR - 1);
      STEP_CLR: hitVal = CNT_W'(LEN_CLR - 1);
      default:  hitVal = CNT_W'(LEN_SHORT - 1);
    endcase
    cntHit = strb.cntRun && (cnt == hitVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.cntClear) begin
      cnt <= '0;
    end else if (strb.cntRun) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (strb.loadCfg) begin
      cfgQ <= cfgIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdData  <= 8'h00;
      initDone <= 1'b0;
    end else begin
      cmdValid <= strb.issue;
      initDone <= strb.done;
      if (strb.issue) begin
        cmdData <= encodeCmd(strb.step, cfgQ);
      end
    end
  end

  // A strobe never lasts longer than one cycle
  assert_strobe_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // Completion is sticky until the next reset
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // The port is quiet once ownership has passed on
  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !cmdValid);

  // Captured configuration does not move after the start phase
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCfg |=> $stable(cfgQ));

  // The hold-off counter never runs past the selected length
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntRun |-> (cnt <= hitVal));

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_init_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned PWR_DIV = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgTwoLines,
  input  logic       cfgTallFont,
  input  logic       cfgDisplayOn,
  input  logic       cfgCursorOn,
  input  logic       cfgBlink,
  input  logic       cfgIncrement,
  input  logic       cfgShiftAll,
  output logic       cmdValid,
  output logic [7:0] cmdData,
  output logic       cmdRs,
  output logic       cmdRw,
  output logic       initDone
);

  seqStrobeT strb;
  panelCfgT  cfgIn;
  logic      cntHit;

  assign cfgIn = '{twoLines: cfgTwoLines, tallFont: cfgTallFont, dispOn: cfgDisplayOn,
                   cursorOn: cfgCursorOn, blinkOn: cfgBlink, increment: cfgIncrement,
                   shiftAll: cfgShiftAll};

  // Every script write targets the instruction register
  assign cmdRs = 1'b0;
  assign cmdRw = 1'b0;

  panel_init_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cntHit (cntHit),
    .strb   (strb)
  );

  panel_init_dp #(
    .CLK_HZ  (CLK_HZ),
    .PWR_DIV (PWR_DIV)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgIn    (cfgIn),
    .cntHit   (cntHit),
    .cmdValid (cmdValid),
    .cmdData  (cmdData),
    .initDone (initDone)
  );

endmodule

// File: tb/test_panel_init_seq.sv
module test_panel_init_seq;

  localparam int unsigned T_CLK_HZ  = 200_000;
  localparam int unsigned T_PWR_DIV = 10;
  localparam int EXP_P = int'(((longint'(T_CLK_HZ) * 30_000) / 1_000_000) / T_PWR_DIV + 1);
  localparam int EXP_S = int'((longint'(T_CLK_HZ) * 39) / 1_000_000 + 1);
  localparam int EXP_C = int'((longint'(T_CLK_HZ) * 1_530) / 1_000_000 + 1);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] cfgDrive = '0;
  logic       cmdValid, cmdRs, cmdRw, initDone;
  logic [7:0] cmdData;

  int totalCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  panel_init_seq #(
    .CLK_HZ  (T_CLK_HZ),
    .PWR_DIV (T_PWR_DIV)
  ) i_panel_init_seq (
    .clk          (clk),
    .rstN         (rstN),
    .cfgTwoLines  (cfgDrive[6]),
    .cfgTallFont  (cfgDrive[5]),
    .cfgDisplayOn (cfgDrive[4]),
    .cfgCursorOn  (cfgDrive[3]),
    .cfgBlink     (cfgDrive[2]),
    .cfgIncrement (cfgDrive[1]),
    .cfgShiftAll  (cfgDrive[0]),
    .cmdValid     (cmdValid),
    .cmdData      (cmdData),
    .cmdRs        (cmdRs),
    .cmdRw        (cmdRw),
    .initDone     (initDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [6:0] cfg);
    int edgeNo = 0;
    int nStrobe = 0;
    int tS [4];
    int dS [4];
    int expT [4];
    int expD [4];
    int expDone;
    int doneAt = -1;
    int badRsRw = 0;
    int wide = 0;
    int dropDone = 0;
    int afterDone = 0;
    bit prevValid = 0;
    string tags [4];

    for (int i = 0; i < 4; i++) begin
      tS[i] = -1;
      dS[i] = -1;
    end
    expT[0] = EXP_P;
    expT[1] = EXP_P + EXP_S;
    expT[2] = EXP_P + 2 * EXP_S;
    expT[3] = EXP_P + 2 * EXP_S + EXP_C;
    expDone = expT[3] + EXP_S;
    expD[0] = 32'h30 | (int'(cfg[6]) << 3) | (int'(cfg[5]) << 2);
    expD[1] = 32'h08 | int'(cfg[4:2]);
    expD[2] = 32'h01;
    expD[3] = 32'h04 | int'(cfg[1:0]);
    tags[0] = "R3 R9 function set";
    tags[1] = "R4 R9 display control";
    tags[2] = "R5 clear";
    tags[3] = "R5 R9 entry mode";

    cfgDrive = cfg;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!cmdValid && !initDone, "R1 reset outputs", {cmdValid, initDone}, 0);
    rstN = 1'b1;
    while (edgeNo < expDone + 12) begin
      @(posedge clk);
      edgeNo++;
      @(negedge clk);
      if (edgeNo == 1) check(!cmdValid && !initDone, "R1 first cycle", {cmdValid, initDone}, 0);
      // Captured at edge 1; inverting afterwards must change nothing
      if (edgeNo == 2) cfgDrive = ~cfg;
      if (cmdValid) begin
        if (nStrobe < 4) begin
          tS[nStrobe] = edgeNo;
          dS[nStrobe] = int'(cmdData);
        end
        nStrobe++;
        if (cmdRs || cmdRw) badRsRw++;
        if (prevValid) wide++;
        if (initDone) afterDone++;
      end
      if (initDone && doneAt < 0) doneAt = edgeNo;
      if (doneAt >= 0 && !initDone) dropDone++;
      prevValid = cmdValid;
    end

    check(nStrobe == 4, "R10 strobe count", nStrobe, 4);
    check(tS[0] == expT[0], "R2 first strobe time", tS[0], expT[0]);
    for (int i = 1; i < 4; i++) begin
      check(tS[i] == expT[i], "R6 strobe spacing", tS[i], expT[i]);
    end
    for (int i = 0; i < 4; i++) begin
      check(dS[i] == expD[i], tags[i], dS[i], expD[i]);
    end
    check(doneAt == expDone, "R7 done time", doneAt, expDone);
    check(dropDone == 0, "R7 done held", dropDone, 0);
    check(afterDone == 0, "R7 quiet after done", afterDone, 0);
    check(badRsRw == 0, "R8 rs/rw zero", badRsRw, 0);
    check(wide == 0, "R8 one-cycle strobe", wide, 0);
  endtask

  initial begin
    for (int c = 0; c < 128; c++) begin
      runOne(7'(c));
    end
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (195_000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule